// File: doc/BRIEF.md
# Processor Execute Stage with Condition Flags

This block carries out the execute step of a single-cycle processor. It takes the decoded instruction code and function code, and the operand words that the fetch and decode steps already produced. From these it builds the arithmetic result word. It keeps a three-flag condition register that later conditional jumps consult, and it chooses the program counter for the next instruction. The register file and the data memory sit outside the block. The memory read word reaches the block only as an input, and it is used for the return target.

Every instruction is presented for exactly one clock cycle, and the block cannot stall. For that reason the data pins are plain and carry no valid/ready pair. The result word, the branch flag and the next program counter are combinational functions of the current inputs and the stored flags. The flags change only at the rising clock edge that ends an arithmetic/logic instruction. Stack adjustment needs no special ALU mode: the operand selector injects a constant of minus or plus one word step (4 bytes), and the ALU adds it.

Top module: `exe_stage`

## Requirements
- R1: Instruction codes are 0 halt, 1 nop, 2 register move, 3 immediate move, 4 store, 5 load, 6 ALU-op, 7 jump, 8 call, 9 return, 10 push and 11 pop. ALU operand A depends on the code:
  - val_a for register move and ALU-op;
  - val_c for immediate move, store and load;
  - -4 for call and push;
  - +4 for return and pop.
- R2: ALU operand B is val_b for store, load, ALU-op, call, push, return and pop. It is zero for register move and immediate move.
- R3: For ALU-op the function comes from the low two bits of ifun: 0 add (B+A), 1 subtract (B-A), 2 bitwise and, 3 bitwise xor. Every other code uses add. val_e is the ALU result, with 32-bit wraparound.
- R4: The condition register loads at the rising clock edge only when the code is ALU-op. Under any other code the flags keep their value.
- R5: The flags are defined as follows:
  - zero is set when the result is 0;
  - sign is bit 31 of the result;
  - overflow is set on signed two's-complement overflow of add or subtract, and is cleared by and/xor.
- R6: Reset (rst_n low, asynchronous) sets zero and clears sign and overflow.
- R7: For a jump, the branch flag is computed from the stored flags according to ifun. Codes 0 to 6 are always, le ((sign^overflow)|zero), l (sign^overflow), e (zero), ne (!zero), ge (!(sign^overflow)) and g (!(sign^overflow)&!zero). Codes 7 to 15 are never taken.
- R8: br_taken is 0 whenever the code is not a jump.
- R9: next_pc is val_c for call, val_c for a taken jump, val_m for return, and val_p for every other case, including a jump that is not taken.
- R10: For halt, nop, jump and the unused codes 12 to 15, both ALU operands are zero, so val_e is 0.
- R11: val_e, br_taken and next_pc settle in the same cycle as the inputs. A flag update first affects br_taken in the cycle after the ALU-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the flags load on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| icode | input | 4 | Instruction code |
| ifun | input | 4 | Function code (ALU function or jump condition) |
| val_a | input | DW | First register operand |
| val_b | input | DW | Second register operand |
| val_c | input | DW | Constant word of the instruction |
| val_p | input | DW | Address of the following instruction |
| val_m | input | DW | Word read from memory (return address) |
| val_e | output | DW | ALU result |
| br_taken | output | 1 | Branch flag for a jump |
| next_pc | output | DW | Program counter for the next instruction |

## Verification
The three outputs are due in the cycle in which the instruction is applied. The bench drives each instruction at a falling edge and compares the outputs a quarter period later, before the rising edge that could change the flags. A flag update becomes visible only in the following instruction's cycle. To check it, each ALU-op is followed by jumps whose expected branch flag comes from the bench's own flag model, which is advanced after the ALU-op's expectation has been queued. Non-ALU instructions are placed between an ALU-op and its jumps to show that the flags held.

// File: rtl/exe_pkg.sv
package exe_pkg;
  localparam int CODE_W = 4;

  localparam logic [CODE_W-1:0] IC_HALT  = 4'd0;
  localparam logic [CODE_W-1:0] IC_NOP   = 4'd1;
  localparam logic [CODE_W-1:0] IC_RRMOV = 4'd2;
  localparam logic [CODE_W-1:0] IC_IRMOV = 4'd3;
  localparam logic [CODE_W-1:0] IC_STORE = 4'd4;
  localparam logic [CODE_W-1:0] IC_LOAD  = 4'd5;
  localparam logic [CODE_W-1:0] IC_ALUOP = 4'd6;
  localparam logic [CODE_W-1:0] IC_JUMP  = 4'd7;
  localparam logic [CODE_W-1:0] IC_CALL  = 4'd8;
  localparam logic [CODE_W-1:0] IC_RET   = 4'd9;
  localparam logic [CODE_W-1:0] IC_PUSH  = 4'd10;
  localparam logic [CODE_W-1:0] IC_POP   = 4'd11;

  typedef enum logic [1:0] {
    FN_ADD = 2'd0,
    FN_SUB = 2'd1,
    FN_AND = 2'd2,
    FN_XOR = 2'd3
  } alu_fn_e;

  localparam logic [CODE_W-1:0] JC_ALWAYS = 4'd0;
  localparam logic [CODE_W-1:0] JC_LE     = 4'd1;
  localparam logic [CODE_W-1:0] JC_LT     = 4'd2;
  localparam logic [CODE_W-1:0] JC_EQ     = 4'd3;
  localparam logic [CODE_W-1:0] JC_NE     = 4'd4;
  localparam logic [CODE_W-1:0] JC_GE     = 4'd5;
  localparam logic [CODE_W-1:0] JC_GT     = 4'd6;

  typedef struct packed {
    logic zf;
    logic sf;
    logic of;
  } flags_t;

  localparam flags_t FLAGS_RESET = '{zf: 1'b1, sf: 1'b0, of: 1'b0};
endpackage

// File: rtl/exe_operand_sel.sv
module exe_operand_sel
  import exe_pkg::*;
#(
  parameter int DW        = 32,
  parameter int STACK_STEP = 4
) (
  input  logic [CODE_W-1:0] icode,
  input  logic [1:0]        op_code,
  input  logic [DW-1:0]     val_a,
  input  logic [DW-1:0]     val_b,
  input  logic [DW-1:0]     val_c,
  output logic [DW-1:0]     opnd_a,
  output logic [DW-1:0]     opnd_b,
  output alu_fn_e           alu_fn,
  output logic              load_flags
);
  localparam logic [DW-1:0] STEP_POS = DW'(STACK_STEP);
  localparam logic [DW-1:0] STEP_NEG = ~STEP_POS + {{(DW-1){1'b0}}, 1'b1};

  always_comb begin
    unique case (icode)
      IC_RRMOV, IC_ALUOP:          opnd_a = val_a;
      IC_IRMOV, IC_STORE, IC_LOAD: opnd_a = val_c;
      IC_CALL, IC_PUSH:            opnd_a = STEP_NEG;
      IC_RET, IC_POP:              opnd_a = STEP_POS;
      default:                     opnd_a = '0;
    endcase
  end

  always_comb begin
    unique case (icode)
      IC_STORE, IC_LOAD, IC_ALUOP,
      IC_CALL, IC_PUSH, IC_RET, IC_POP: opnd_b = val_b;
      default:                          opnd_b = '0;
    endcase
  end

  always_comb begin
    load_flags = (icode == IC_ALUOP);
    alu_fn     = load_flags ? alu_fn_e'(op_code) : FN_ADD;
  end
endmodule

// File: rtl/exe_alu.sv
module exe_alu
  import exe_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] opnd_a,
  input  logic [DW-1:0] opnd_b,
  input  alu_fn_e       alu_fn,
  output logic [DW-1:0] result,
  output flags_t        flags
);
  localparam int MSB = DW - 1;

  logic [DW-1:0] sum_w;
  logic [DW-1:0] dif_w;
  logic          ovf_add;
  logic          ovf_sub;

  always_comb begin
    sum_w   = opnd_b + opnd_a;
    dif_w   = opnd_b - opnd_a;
    // operands of equal sign, result sign differs from them
    ovf_add = (opnd_a[MSB] == opnd_b[MSB]) && (sum_w[MSB] != opnd_b[MSB]);
    // operands of opposite sign, result sign differs from the minuend
    ovf_sub = (opnd_a[MSB] != opnd_b[MSB]) && (dif_w[MSB] != opnd_b[MSB]);
  end

  always_comb begin
    flags.of = 1'b0;
    unique case (alu_fn)
      FN_ADD: begin result = sum_w; flags.of = ovf_add; end
      FN_SUB: begin result = dif_w; flags.of = ovf_sub; end
      FN_AND: result = opnd_a & opnd_b;
      FN_XOR: result = opnd_a ^ opnd_b;
      default: result = sum_w;
    endcase
    flags.zf = (result == '0);
    flags.sf = result[MSB];
  end
endmodule

// File: rtl/exe_cond_unit.sv
module exe_cond_unit
  import exe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_flags,
  input  flags_t            flags_in,
  input  logic              is_jump,
  input  logic [CODE_W-1:0] cond_code,
  output flags_t            flags_q,
  output logic              taken
);
  logic lt_w;
  logic cond_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flags_q <= FLAGS_RESET;
    else if (load_flags) flags_q <= flags_in;
  end

  always_comb begin
    lt_w = flags_q.sf ^ flags_q.of;
    unique case (cond_code)
      JC_ALWAYS: cond_w = 1'b1;
      JC_LE:     cond_w = lt_w | flags_q.zf;
      JC_LT:     cond_w = lt_w;
      JC_EQ:     cond_w = flags_q.zf;
      JC_NE:     cond_w = ~flags_q.zf;
      JC_GE:     cond_w = ~lt_w;
      JC_GT:     cond_w = ~lt_w & ~flags_q.zf;
      default:   cond_w = 1'b0;
    endcase
    taken = is_jump & cond_w;
  end
endmodule

// File: rtl/exe_pc_sel.sv
module exe_pc_sel
  import exe_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [CODE_W-1:0] icode,
  input  logic              taken,
  input  logic [DW-1:0]     val_c,
  input  logic [DW-1:0]     val_p,
  input  logic [DW-1:0]     val_m,
  output logic [DW-1:0]     next_pc
);
  always_comb begin
    if (icode == IC_CALL)                next_pc = val_c;
    else if (icode == IC_JUMP && taken)  next_pc = val_c;
    else if (icode == IC_RET)            next_pc = val_m;
    else                                 next_pc = val_p;
  end
endmodule

// File: rtl/exe_stage.sv
module exe_stage
  import exe_pkg::*;
#(
  parameter int DW         = 32,
  parameter int STACK_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] icode,
  input  logic [CODE_W-1:0] ifun,
  input  logic [DW-1:0]     val_a,
  input  logic [DW-1:0]     val_b,
  input  logic [DW-1:0]     val_c,
  input  logic [DW-1:0]     val_p,
  input  logic [DW-1:0]     val_m,
  output logic [DW-1:0]     val_e,
  output logic              br_taken,
  output logic [DW-1:0]     next_pc
);
  logic [DW-1:0] opnd_a;
  logic [DW-1:0] opnd_b;
  alu_fn_e       alu_fn;
  logic          load_flags;
  flags_t        alu_flags;
  flags_t        cc_q;
  logic          taken;

  exe_operand_sel #(.DW(DW), .STACK_STEP(STACK_STEP)) u_opsel (
    .icode      (icode),
    .op_code    (ifun[1:0]),
    .val_a      (val_a),
    .val_b      (val_b),
    .val_c      (val_c),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .alu_fn     (alu_fn),
    .load_flags (load_flags)
  );

  exe_alu #(.DW(DW)) u_alu (
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .alu_fn (alu_fn),
    .result (val_e),
    .flags  (alu_flags)
  );

  exe_cond_unit u_cond (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_flags (load_flags),
    .flags_in   (alu_flags),
    .is_jump    (icode == IC_JUMP),
    .cond_code  (ifun),
    .flags_q    (cc_q),
    .taken      (taken)
  );

  exe_pc_sel #(.DW(DW)) u_pcsel (
    .icode   (icode),
    .taken   (taken),
    .val_c   (val_c),
    .val_p   (val_p),
    .val_m   (val_m),
    .next_pc (next_pc)
  );

  assign br_taken = taken;
endmodule

// File: rtl/exe_stage_chk.sv
module exe_stage_chk
  import exe_pkg::*;
#(
  parameter int DW         = 32,
  parameter int STACK_STEP = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] icode,
  input logic [CODE_W-1:0] ifun,
  input logic [DW-1:0]     val_b,
  input logic [DW-1:0]     val_c,
  input logic [DW-1:0]     val_m,
  input logic [DW-1:0]     val_e,
  input logic              br_taken,
  input logic [DW-1:0]     next_pc,
  input flags_t            cc_q
);
  localparam logic [DW-1:0] STEP_W = DW'(STACK_STEP);

  AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (icode == IC_PUSH) |-> (val_e == val_b - STEP_W)); // R1
  AST_POP_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (icode == IC_POP) |-> (val_e == val_b + STEP_W)); // R1
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (icode != IC_ALUOP) |=> $stable(cc_q)); // R4
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (icode == IC_ALUOP) |=> (cc_q.zf == ($past(val_e) == '0))); // R5
  AST_SIGN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (icode == IC_ALUOP) |=> (cc_q.sf == $past(val_e[DW-1]))); // R5
  AST_LOGIC_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (icode == IC_ALUOP && ifun[1]) |=> !cc_q.of); // R5
  AST_RESET_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cc_q == FLAGS_RESET)); // R6
  AST_JUMP_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (icode == IC_JUMP && ifun == JC_ALWAYS) |-> br_taken); // R7
  AST_NO_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    (icode != IC_JUMP) |-> !br_taken); // R8
  AST_CALL_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (icode == IC_CALL) |-> (next_pc == val_c)); // R9
  AST_RET_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (icode == IC_RET) |-> (next_pc == val_m)); // R9
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (icode == IC_HALT || icode == IC_NOP || icode == IC_JUMP) |-> (val_e == '0)); // R10
endmodule

bind exe_stage exe_stage_chk #(.DW(DW), .STACK_STEP(STACK_STEP)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .icode    (icode),
  .ifun     (ifun),
  .val_b    (val_b),
  .val_c    (val_c),
  .val_m    (val_m),
  .val_e    (val_e),
  .br_taken (br_taken),
  .next_pc  (next_pc),
  .cc_q     (cc_q)
);

// File: tb/exe_stage_tb_top.sv
module exe_stage_tb_top;
  localparam int CLK_PER = 10;
  localparam int DW      = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    icode = 4'd1;
  logic [3:0]    ifun = 4'd0;
  logic [DW-1:0] val_a = '0, val_b = '0, val_c = '0, val_p = '0, val_m = '0;
  logic [DW-1:0] val_e;
  logic          br_taken;
  logic [DW-1:0] next_pc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [DW-1:0] e;
    logic          br;
    logic [DW-1:0] pc;
    string         tag;
  } exp_t;
  exp_t sb_q[$];

  // bench flag model
  bit m_z = 1'b1, m_s = 1'b0, m_o = 1'b0;
  logic [31:0] rng = 32'h1234_5678;

  always #(CLK_PER/2) clk = ~clk;

  exe_stage #(.DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .icode(icode), .ifun(ifun),
    .val_a(val_a), .val_b(val_b), .val_c(val_c), .val_p(val_p), .val_m(val_m),
    .val_e(val_e), .br_taken(br_taken), .next_pc(next_pc)
  );

  function automatic logic [31:0] next_rand(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: apply one instruction at a falling edge and queue its expectation
  task automatic issue(input logic [3:0] ic, input logic [3:0] fn,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] c, input logic [31:0] p,
                       input logic [31:0] m, input string tag);
    logic [31:0] x, y, res;
    longint      wide;
    bit          ovf, cnd, br;
    exp_t        it;
    @(negedge clk);
    icode = ic; ifun = fn; val_a = a; val_b = b; val_c = c; val_p = p; val_m = m;
    x = 32'd0; y = 32'd0;
    if (ic == 4'd2 || ic == 4'd6) x = a;
    else if (ic == 4'd3 || ic == 4'd4 || ic == 4'd5) x = c;
    else if (ic == 4'd8 || ic == 4'd10) x = 32'hFFFF_FFFC;
    else if (ic == 4'd9 || ic == 4'd11) x = 32'd4;
    if (ic >= 4'd4 && ic <= 4'd11 && ic != 4'd7) y = b;
    ovf = 1'b0;
    if (ic == 4'd6 && fn[1:0] == 2'd2) res = x & y;
    else if (ic == 4'd6 && fn[1:0] == 2'd3) res = x ^ y;
    else begin
      if (ic == 4'd6 && fn[1:0] == 2'd1)
        wide = longint'($signed(y)) - longint'($signed(x));
      else
        wide = longint'($signed(y)) + longint'($signed(x));
      res = wide[31:0];
      ovf = (wide != longint'($signed(res)));
    end
    case (fn)
      4'd0: cnd = 1'b1;
      4'd1: cnd = (m_s != m_o) || m_z;
      4'd2: cnd = (m_s != m_o);
      4'd3: cnd = m_z;
      4'd4: cnd = !m_z;
      4'd5: cnd = (m_s == m_o);
      4'd6: cnd = (m_s == m_o) && !m_z;
      default: cnd = 1'b0;
    endcase
    br = (ic == 4'd7) && cnd;
    it.e = res;
    it.br = br;
    it.pc = (ic == 4'd8 || br) ? c : (ic == 4'd9 ? m : p);
    it.tag = tag;
    sb_q.push_back(it);
    if (ic == 4'd6) begin
      m_z = (res == 32'd0);
      m_s = res[31];
      m_o = ovf;
    end
  endtask

  // monitor: compare a quarter period after each drive
  initial begin
    exp_t it;
    forever begin
      @(negedge clk);
      #(CLK_PER/4);
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        check(val_e == it.e, it.tag, "val_e", val_e, it.e);
        check(br_taken == it.br, it.tag, "br_taken", {31'd0, br_taken}, {31'd0, it.br});
        check(next_pc == it.pc, it.tag, "next_pc", next_pc, it.pc);
      end
    end
  end

  initial begin
    #(CLK_PER * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // reset state: nop during reset, R6 flags observed by jumps after release
    issue(4'd1, 4'd0, 32'd5, 32'd6, 32'd7, 32'h100, 32'h200, "R10 nop in reset");
    @(negedge clk);
    rst_n = 1'b1;
    issue(4'd7, 4'd3, 0, 0, 32'h400, 32'h104, 0, "R6 je after reset");
    issue(4'd7, 4'd4, 0, 0, 32'h400, 32'h104, 0, "R6 jne after reset");
    issue(4'd7, 4'd6, 0, 0, 32'h400, 32'h104, 0, "R6 jg after reset");
    // R3 add, R5 flags, R7 conditions
    issue(4'd6, 4'd0, 32'd5, 32'd7, 0, 32'h108, 0, "R3 add");
    issue(4'd7, 4'd4, 0, 0, 32'h500, 32'h10C, 0, "R7 jne after add");
    issue(4'd7, 4'd3, 0, 0, 32'h500, 32'h10C, 0, "R7 je after add");
    issue(4'd7, 4'd6, 0, 0, 32'h500, 32'h10C, 0, "R7 jg after add");
    issue(4'd7, 4'd2, 0, 0, 32'h500, 32'h10C, 0, "R7 jl after add");
    issue(4'd6, 4'd1, 32'd5, 32'd3, 0, 32'h110, 0, "R3 sub B-A negative");
    issue(4'd7, 4'd2, 0, 0, 32'h600, 32'h114, 0, "R7 jl after sub");
    issue(4'd7, 4'd1, 0, 0, 32'h600, 32'h114, 0, "R7 jle after sub");
    issue(4'd7, 4'd5, 0, 0, 32'h600, 32'h114, 0, "R7 jge after sub");
    issue(4'd6, 4'd0, 32'd1, 32'h7FFF_FFFF, 0, 32'h118, 0, "R5 add overflow");
    issue(4'd7, 4'd2, 0, 0, 32'h700, 32'h11C, 0, "R5 jl with overflow");
    issue(4'd7, 4'd5, 0, 0, 32'h700, 32'h11C, 0, "R5 jge with overflow");
    issue(4'd6, 4'd1, 32'd1, 32'h8000_0000, 0, 32'h120, 0, "R5 sub overflow");
    issue(4'd7, 4'd2, 0, 0, 32'h700, 32'h124, 0, "R5 jl after sub overflow");
    issue(4'd6, 4'd2, 32'h8000_0000, 32'hFFFF_FFFF, 0, 32'h128, 0, "R5 and clears overflow");
    issue(4'd7, 4'd2, 0, 0, 32'h700, 32'h12C, 0, "R5 jl after and");
    issue(4'd6, 4'd3, 32'hA5A5_5A5A, 32'hA5A5_5A5A, 0, 32'h130, 0, "R3 xor to zero");
    // R1 R2 R9 R10 R4: non-ALU instructions leave the zero flag set
    issue(4'd2, 4'd0, 32'hDEAD_0001, 32'h1111, 32'h2222, 32'h134, 0, "R2 register move");
    issue(4'd3, 4'd0, 32'h3333, 32'h1111, 32'h0BEE_F000, 32'h136, 0, "R2 immediate move");
    issue(4'd4, 4'd0, 32'h3333, 32'h1000, 32'h24, 32'h13C, 0, "R1 store address");
    issue(4'd5, 4'd0, 32'h3333, 32'h2000, 32'h8, 32'h142, 0, "R1 load address");
    issue(4'd8, 4'd0, 0, 32'h8000, 32'h900, 32'h148, 0, "R9 call");
    issue(4'd10, 4'd0, 32'h55, 32'h8000, 0, 32'h14D, 0, "R1 push");
    issue(4'd9, 4'd0, 0, 32'h7FFC, 0, 32'h14E, 32'h14D, "R9 return");
    issue(4'd11, 4'd0, 0, 32'h7FFC, 0, 32'h150, 0, "R1 pop");
    issue(4'd0, 4'd0, 32'h9, 32'h9, 32'h9, 32'h152, 0, "R10 halt");
    issue(4'd14, 4'd6, 32'h9, 32'h9, 32'h9, 32'h153, 0, "R8 unused code");
    issue(4'd7, 4'd3, 0, 0, 32'hA00, 32'h154, 0, "R4 je flags held");
    issue(4'd7, 4'd7, 0, 0, 32'hA00, 32'h159, 0, "R7 code 7 never");
    issue(4'd7, 4'd0, 0, 0, 32'hA04, 32'h15E, 0, "R7 always");
    issue(4'd6, 4'd0, 32'hFFFF_FFFF, 32'd1, 0, 32'h163, 0, "R11 add wrap to zero");
    issue(4'd7, 4'd3, 0, 0, 32'hB00, 32'h165, 0, "R11 je next cycle");
    // mixed operations followed by all jump conditions
    for (int i = 0; i < 60; i++) begin
      logic [31:0] ra, rb;
      rng = next_rand(rng); ra = rng;
      rng = next_rand(rng); rb = rng;
      if (i % 3 == 0) ra = ra >> 28;
      if (i % 5 == 0) rb = ra;
      issue(4'd6, {2'b00, rng[1:0]}, ra, rb, 0, 32'h200 + i, 0, "R3 mixed op");
      issue(4'd7, {1'b0, rng[9:7]}, 0, 0, 32'hC00 + i, 32'h300 + i, 0, "R7 mixed jump");
    end
    @(negedge clk);
    #(CLK_PER/2);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule